// File: doc/BRIEF.md
# TDM Time-Slot Channel Mapper

This block follows the time slots of one serial TDM port and maps each received octet to a logical channel. A shared slot-descriptor store holds one word per slot. A pointer register marks the first and last slot address that this port owns in that store. For every octet strobe, the mapper looks up the descriptor of the current slot. One cycle later it presents the channel number, a valid flag, the kept data bits and a per-bit keep vector.

Each descriptor carries three controls: an enable bit that blocks the slot, a subchannel bit that selects a per-slot data mask, and a last-slot flag. The mapper raises a channel poll only on a slot whose last-slot flag is set. A channel that spans several slots is therefore polled once per frame. A programmable throttle stretches this further, so that polls occur in only one of every N frames.

Software configures all of this through a write-only register port. The pointer can be changed only while the port is disabled.

Top module: `tdm_slot_mapper`

## Requirements
- R1: After reset, the port is disabled and `ch_valid`, `ch_poll`, `ch_id`, `ch_data` and `ch_keep` are all zero.
- R2: An octet strobe that comes with `fsync` uses the start slot address. Each later strobe uses the next slot address. After the end address, the slot address returns to the start address, with or without `fsync`.
- R3: The mapped result appears exactly one clock after the strobe. `ch_id` equals descriptor bits 12:3 of the slot used. No strobe means `ch_valid` and `ch_poll` are low in the next cycle.
- R4: Descriptor bit 2 is the slot enable. When it is 0, the strobe gives `ch_valid`=0, `ch_poll`=0 and zero data, id and keep.
- R5: Descriptor bit 1 selects subchanneling. When it is 0, `ch_keep`=FF and `ch_data` is the full octet. When it is 1, `ch_keep` is the slot's mask register and `ch_data` is the octet AND that mask.
- R6: Descriptor bit 0 is the last-slot flag. `ch_poll` rises only with a valid slot whose flag is 1, and only in a frame the throttle allows.
- R7: Mode field bits 7:4 hold a throttle value t. Frames are numbered from 0, starting at the first `fsync` after the port is enabled. Polls are allowed only in frames whose number is a multiple of t+1.
- R8: The mode register bit 0 is the port enable. While it is 0, and after enabling until the first `fsync` strobe, no strobe produces `ch_valid` or `ch_poll`.
- R9: Writes to the pointer register are ignored while the port is enabled.
- R10: Descriptor bits 31:13 are reserved and have no effect on any output.

Register map: `cfg_addr` = {space[1:0], index}.
- Space 0 is the descriptor store, one word per slot.
- Space 1 is the mask store. Mask bits 7:0 apply to each slot.
- Space 2 is control.
  - Index 0 is the pointer: the start address in bits 6:0 and the end address in bits 22:16, with start ≤ end.
  - Index 1 is the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register address: {space, index} |
| cfg_wdata | input | 32 | Register write data |
| fsync | input | 1 | Marks the strobe that carries the first slot of a frame |
| oct_vld | input | 1 | Octet strobe |
| oct_data | input | 8 | Received octet |
| ch_valid | output | 1 | Mapped octet present |
| ch_id | output | 10 | Logical channel number |
| ch_data | output | 8 | Octet with masked-off bits forced to zero |
| ch_keep | output | 8 | Per-bit keep vector |
| ch_poll | output | 1 | Once-per-frame service request for `ch_id` |

## Verification
A slot counter that has drifted shows up one cycle after the next strobe. It presents a `ch_id` or keep pattern that belongs to a neighbouring slot, and it does so within the first frame after the fault. A wrong frame count is visible only at poll time. It shows as a poll in a frame the throttle should have suppressed, or a missing one, within t+1 frames. A bad enable or sync flag shows as valid output before the first `fsync` or while the port is disabled. The bench therefore compares every strobe's result against a model and checks for silence on idle cycles.

// File: rtl/tsmap_pkg.sv
package tsmap_pkg;

    localparam int CH_W  = 10;
    localparam int OCT_W = 8;
    localparam int THR_W = 4;
    localparam int DSC_W = CH_W + 3;

    // descriptor field layout, decoded from the low bits of the written word
    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            en;
        logic            sub;
        logic            last;
    } slot_desc_t;

    typedef enum logic [1:0] {
        SP_DESC = 2'd0,
        SP_MASK = 2'd1,
        SP_CTRL = 2'd2,
        SP_NONE = 2'd3
    } space_e;

    typedef struct packed {
        logic             valid;
        logic [CH_W-1:0]  chan;
        logic [OCT_W-1:0] data;
        logic [OCT_W-1:0] keep;
        logic             poll;
    } chan_out_t;

    function automatic logic [OCT_W-1:0] keep_bits(slot_desc_t d, logic [OCT_W-1:0] m);
        if (!d.en)
            return '0;
        return d.sub ? m : {OCT_W{1'b1}};
    endfunction

endpackage

// File: rtl/tsmap_regs.sv
module tsmap_regs
    import tsmap_pkg::*;
#(
    parameter int SLOT_AW = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [SLOT_AW+1:0]   cfg_addr,
    input  logic [31:0]          cfg_wdata,
    input  logic                 rd_en,
    input  logic [SLOT_AW-1:0]   rd_addr,
    output slot_desc_t           rd_desc,
    output logic [OCT_W-1:0]     rd_mask,
    output logic [SLOT_AW-1:0]   start_addr,
    output logic [SLOT_AW-1:0]   end_addr,
    output logic                 port_en,
    output logic [THR_W-1:0]     thr
);

    localparam int NSLOT = 1 << SLOT_AW;
    localparam logic [SLOT_AW-1:0] PTR_IDX  = SLOT_AW'(0);
    localparam logic [SLOT_AW-1:0] MODE_IDX = SLOT_AW'(1);

    space_e             sp;
    logic [SLOT_AW-1:0] idx;
    logic               unused_bits;

    assign sp  = space_e'(cfg_addr[SLOT_AW+1:SLOT_AW]);
    assign idx = cfg_addr[SLOT_AW-1:0];
    assign unused_bits = ^{cfg_wdata[15:DSC_W], cfg_wdata[31:16+SLOT_AW]};

    // descriptor and mask stores: no reset value by design
    slot_desc_t       desc_mem [NSLOT];
    logic [OCT_W-1:0] mask_mem [NSLOT];

    always_ff @(posedge clk) begin
        if (cfg_we && sp == SP_DESC)
            desc_mem[idx] <= slot_desc_t'(cfg_wdata[DSC_W-1:0]);
        if (cfg_we && sp == SP_MASK)
            mask_mem[idx] <= cfg_wdata[OCT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_desc <= desc_mem[rd_addr];
            rd_mask <= mask_mem[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_addr <= '0;
            end_addr   <= '0;
            port_en    <= 1'b0;
            thr        <= '0;
        end else if (cfg_we && sp == SP_CTRL) begin
            if (idx == PTR_IDX && !port_en) begin
                start_addr <= cfg_wdata[SLOT_AW-1:0];
                end_addr   <= cfg_wdata[16+SLOT_AW-1:16];
            end
            if (idx == MODE_IDX) begin
                port_en <= cfg_wdata[0];
                thr     <= cfg_wdata[4+THR_W-1:4];
            end
        end
    end

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (port_en && $past(port_en)) |-> ($stable(start_addr) && $stable(end_addr))); // R9

endmodule

// File: rtl/tsmap_seq.sv
module tsmap_seq
    import tsmap_pkg::*;
#(
    parameter int SLOT_AW = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               port_en,
    input  logic [SLOT_AW-1:0] start_addr,
    input  logic [SLOT_AW-1:0] end_addr,
    input  logic [THR_W-1:0]   thr,
    input  logic               oct_vld,
    input  logic               fsync,
    output logic [SLOT_AW-1:0] slot_addr,
    output logic               slot_go,
    output logic               frame_ok
);

    logic [SLOT_AW-1:0] cnt;
    logic [THR_W-1:0]   fcnt;
    logic [THR_W-1:0]   fr_cur;
    logic               synced;

    always_comb begin
        if (fsync) begin
            slot_addr = start_addr;
            fr_cur    = (synced && fcnt < thr) ? fcnt + 1'b1 : '0;
            slot_go   = port_en && oct_vld;
        end else begin
            slot_addr = cnt;
            fr_cur    = fcnt;
            slot_go   = port_en && oct_vld && synced;
        end
        frame_ok = (fr_cur == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !port_en) begin
            synced <= 1'b0;
            fcnt   <= '0;
            cnt    <= start_addr;
        end else if (slot_go) begin
            synced <= 1'b1;
            fcnt   <= fr_cur;
            cnt    <= (slot_addr == end_addr) ? start_addr : slot_addr + 1'b1;
        end
    end

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        synced |-> (cnt >= start_addr && cnt <= end_addr)); // R2

    AST_FIRST_FRAME_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(synced) |-> (fcnt == '0)); // R7

endmodule

// File: rtl/tsmap_out.sv
module tsmap_out
    import tsmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_go,
    input  logic             frame_ok,
    input  logic [OCT_W-1:0] oct_data,
    input  slot_desc_t       desc,
    input  logic [OCT_W-1:0] mask,
    output chan_out_t        res
);

    logic             go_q;
    logic             ok_q;
    logic [OCT_W-1:0] data_q;
    logic [OCT_W-1:0] keep;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q   <= 1'b0;
            ok_q   <= 1'b0;
            data_q <= '0;
        end else begin
            go_q <= slot_go;
            if (slot_go) begin
                ok_q   <= frame_ok;
                data_q <= oct_data;
            end
        end
    end

    always_comb begin
        res  = '0;
        keep = keep_bits(desc, mask);
        if (go_q && desc.en) begin
            res.valid = 1'b1;
            res.chan  = desc.chan;
            res.keep  = keep;
            res.data  = data_q & keep;
            res.poll  = desc.last && ok_q;
        end
    end

    AST_POLL_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        res.poll |-> res.valid); // R6

endmodule

// File: rtl/tdm_slot_mapper.sv
module tdm_slot_mapper
    import tsmap_pkg::*;
#(
    parameter int SLOT_AW = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [SLOT_AW+1:0] cfg_addr,
    input  logic [31:0]        cfg_wdata,
    input  logic               fsync,
    input  logic               oct_vld,
    input  logic [OCT_W-1:0]   oct_data,
    output logic               ch_valid,
    output logic [CH_W-1:0]    ch_id,
    output logic [OCT_W-1:0]   ch_data,
    output logic [OCT_W-1:0]   ch_keep,
    output logic               ch_poll
);

    slot_desc_t         rd_desc;
    logic [OCT_W-1:0]   rd_mask;
    logic [SLOT_AW-1:0] start_addr;
    logic [SLOT_AW-1:0] end_addr;
    logic               port_en;
    logic [THR_W-1:0]   thr;
    logic [SLOT_AW-1:0] slot_addr;
    logic               slot_go;
    logic               frame_ok;
    chan_out_t          res;

    tsmap_regs #(.SLOT_AW(SLOT_AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .rd_en      (slot_go),
        .rd_addr    (slot_addr),
        .rd_desc    (rd_desc),
        .rd_mask    (rd_mask),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .port_en    (port_en),
        .thr        (thr)
    );

    tsmap_seq #(.SLOT_AW(SLOT_AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .port_en    (port_en),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .thr        (thr),
        .oct_vld    (oct_vld),
        .fsync      (fsync),
        .slot_addr  (slot_addr),
        .slot_go    (slot_go),
        .frame_ok   (frame_ok)
    );

    tsmap_out u_out (
        .clk      (clk),
        .rst      (rst),
        .slot_go  (slot_go),
        .frame_ok (frame_ok),
        .oct_data (oct_data),
        .desc     (rd_desc),
        .mask     (rd_mask),
        .res      (res)
    );

    assign ch_valid = res.valid;
    assign ch_id    = res.chan;
    assign ch_data  = res.data;
    assign ch_keep  = res.keep;
    assign ch_poll  = res.poll;

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        ch_valid |-> $past(oct_vld)); // R3

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> !ch_valid); // R8

endmodule

// File: tb/tb_tdm_slot_mapper.sv
module tb_tdm_slot_mapper;

    localparam int SW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [SW+1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          fsync = 1'b0;
    logic          oct_vld = 1'b0;
    logic [7:0]    oct_data = '0;
    logic          ch_valid;
    logic [9:0]    ch_id;
    logic [7:0]    ch_data;
    logic [7:0]    ch_keep;
    logic          ch_poll;

    always #5 clk = ~clk;

    tdm_slot_mapper #(.SLOT_AW(SW)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fsync(fsync), .oct_vld(oct_vld),
        .oct_data(oct_data), .ch_valid(ch_valid), .ch_id(ch_id),
        .ch_data(ch_data), .ch_keep(ch_keep), .ch_poll(ch_poll)
    );

    typedef struct packed {
        logic       v;
        logic [9:0] id;
        logic [7:0] d;
        logic [7:0] k;
        logic       p;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    logic  pend = 1'b0;

    // bench-side view of the configuration and port state
    logic [31:0] m_desc [128];
    logic [7:0]  m_mask [128];
    int m_start = 0, m_end = 0, m_thr = 0, m_cnt = 0, m_f = 0;
    bit m_en = 0, m_sync = 0;

    task automatic cfg(input logic [1:0] sp, input int idx, input logic [31:0] w);
        @(negedge clk);
        oct_vld = 1'b0; fsync = 1'b0;
        cfg_we = 1'b1; cfg_addr = {sp, 7'(idx)}; cfg_wdata = w;
        if (sp == 2'd0) m_desc[idx] = w;
        if (sp == 2'd1) m_mask[idx] = w[7:0];
        if (sp == 2'd2 && idx == 0 && !m_en) begin
            m_start = int'(w[6:0]); m_end = int'(w[22:16]);
        end
        if (sp == 2'd2 && idx == 1) begin
            m_en = w[0]; m_thr = int'(w[7:4]);
            if (!m_en) begin m_sync = 0; m_f = 0; end
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic oct(input logic fs, input logic [7:0] d);
        exp_t e;
        int slot, fr;
        bit go;
        @(negedge clk);
        cfg_we = 1'b0;
        fsync = fs; oct_vld = 1'b1; oct_data = d;
        e = '0; go = 0; slot = 0; fr = 0;
        if (m_en && fs) begin
            fr = (m_sync && m_f < m_thr) ? m_f + 1 : 0;
            slot = m_start; go = 1; m_sync = 1;
        end else if (m_en && m_sync) begin
            slot = m_cnt; fr = m_f; go = 1;
        end
        if (go) begin
            m_f = fr;
            m_cnt = (slot == m_end) ? m_start : slot + 1;
            if (m_desc[slot][2]) begin
                e.v  = 1'b1;
                e.id = m_desc[slot][12:3];
                e.k  = m_desc[slot][1] ? m_mask[slot] : 8'hFF;
                e.d  = d & e.k;
                e.p  = m_desc[slot][0] && (fr == 0);
            end
        end
        expq.push_back(e);
        tagq.push_back(cur_req);
    endtask

    task automatic idle();
        @(negedge clk);
        oct_vld = 1'b0; fsync = 1'b0; cfg_we = 1'b0;
    endtask

    always @(posedge clk) pend <= oct_vld && !rst;

    // monitor: one expected item per strobe, silence otherwise
    always @(negedge clk) begin
        if (!rst) begin
            if (pend && expq.size() > 0) begin
                exp_t e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                n_chk++;
                if ({ch_valid, ch_id, ch_data, ch_keep, ch_poll} !== e) begin
                    n_err++;
                    $display("FAIL %s: got v=%b id=%0d d=%h k=%h p=%b exp v=%b id=%0d d=%h k=%h p=%b",
                             t, ch_valid, ch_id, ch_data, ch_keep, ch_poll, e.v, e.id, e.d, e.k, e.p);
                end
            end else if (!pend) begin
                n_chk++;
                if (ch_valid !== 1'b0 || ch_poll !== 1'b0) begin
                    n_err++;
                    $display("FAIL R3: idle cycle got v=%b p=%b exp v=0 p=0", ch_valid, ch_poll);
                end
            end
        end
    end

    bit done = 0;
    initial begin
        #2_000_000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: got hang exp completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) begin m_desc[i] = '0; m_mask[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        n_chk++;
        if ({ch_valid, ch_id, ch_data, ch_keep, ch_poll} !== '0) begin
            n_err++;
            $display("FAIL R1: got %b exp 0", {ch_valid, ch_id, ch_data, ch_keep, ch_poll});
        end

        // slots 4..7; R10 reserved bits set on slot 4
        cfg(2'd2, 0, (32'd7 << 16) | 32'd4);
        cfg(2'd0, 4, 32'hFFFF_E000 | (32'd5 << 3) | 32'h5);
        cfg(2'd0, 5, (32'd9 << 3) | 32'h4);
        cfg(2'd1, 5, 32'hF0);
        cfg(2'd0, 6, (32'd9 << 3) | 32'h7);
        cfg(2'd1, 6, 32'h0F);
        cfg(2'd0, 7, (32'd3 << 3) | 32'h1);
        cfg(2'd0, 10, (32'd1023 << 3) | 32'h7);
        cfg(2'd1, 10, 32'hA5);

        cur_req = "R8";                       // disabled port stays silent
        oct(1'b1, 8'h11); oct(1'b0, 8'h22); idle();
        cfg(2'd2, 1, 32'h1);
        oct(1'b0, 8'h33); oct(1'b0, 8'h44); idle();   // enabled, not yet synced

        cur_req = "R4";                       // R2 R3 R5 R6 R10 also covered
        for (int f = 0; f < 3; f++) begin
            oct(1'b1, 8'h3C); oct(1'b0, 8'hC3); oct(1'b0, 8'h5A); oct(1'b0, 8'hFF);
        end
        idle(); idle();
        cur_req = "R2";                       // wrap with no fsync
        for (int i = 0; i < 6; i++) oct(1'b0, 8'(8'h10 + i));
        idle();
        cur_req = "R9";                       // pointer write ignored while enabled
        cfg(2'd2, 0, (32'd1 << 16) | 32'd0);
        oct(1'b1, 8'h81); oct(1'b0, 8'h82); oct(1'b0, 8'h83); oct(1'b0, 8'h84);
        idle();

        cur_req = "R7";                       // throttle t=2 on a single-slot port
        cfg(2'd2, 1, 32'h0);
        cfg(2'd2, 0, (32'd10 << 16) | 32'd10);
        cfg(2'd2, 1, (32'd2 << 4) | 32'h1);
        for (int f = 0; f < 7; f++) begin
            oct(1'b1, 8'(8'h60 + f));
            oct(1'b0, 8'hE7);
        end
        idle();
        cur_req = "R8";
        cfg(2'd2, 1, 32'h0);
        oct(1'b1, 8'h99); oct(1'b0, 8'h98);
        idle(); idle(); idle();

        done = 1;
        if (expq.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL R3: got %0d results pending exp 0", expq.size());
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule